// File: doc/BRIEF.md
# Poison-Bit Selective Squash Tracker

This block limits the damage of a mis-speculated load to the instructions that actually consumed its bad value. It keeps one poison bit per physical register. When the memory ordering logic reports that a load read stale data, the load's destination register becomes poisoned. Every instruction that issues afterwards is checked against these bits: if any of its valid source registers is poisoned, the block flags that instruction for squash and poisons the register it would write. The mark therefore travels along the dataflow graph through direct and indirect consumers, while instructions that touch no poisoned register carry on untouched.

Several instructions may issue in one cycle. They are treated as ordered by slot index, with slot 0 the oldest, so a younger slot that reads the destination of an older, squashed slot in the same group is also squashed. A violation report is visible to readers in the cycle it arrives. A poison bit is removed when the replayed producer writes back a correct result on one of the clear ports; the downstream commit logic uses the squash flags to hold poisoned work back until that replay has happened.

Top module: `pt_squash_tracker`

## Requirements
- R1: Reset clears every poison bit, so after reset and with no violation report no issuing instruction is squashed.
- R2: A violation report for register T makes T poisoned from the next cycle on, so a later reader of T is squashed.
- R3: An instruction that reads T in the same cycle as a violation report for T is squashed (the report is bypassed to the readers).
- R4: An instruction is squashed when any of its source positions (0 or 1) is valid and names a poisoned register; a source whose valid bit is 0 is ignored whatever its tag.
- R5: A squashed instruction with a valid destination D poisons D from the next cycle, so readers of D in later cycles are squashed (indirect dependents).
- R6: Within one issue group slot 0 is oldest; a slot that reads the valid destination of an older squashed slot in the same cycle is squashed, while an older slot is never affected by a younger one.
- R7: An instruction whose valid sources are all clean is not squashed, and a slot whose issue valid is 0 never reports a squash.
- R8: A clear on a writeback port for register T removes its poison from the next cycle; a reader of T in the clear cycle itself still sees the poison.
- R9: When a register is both poisoned (by a violation or a squashed producer) and cleared in the same cycle, the poison wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| viol_valid | input | 1 | A load has been found to have read stale data |
| viol_tag | input | TAG_W | Destination register of that load |
| iss_valid | input | ISSUE_W | Per-slot issue valid, slot 0 oldest |
| iss_src_valid | input | ISSUE_W*NUM_SRC | Source valid, entry slot*NUM_SRC+src |
| iss_src_tag | input | ISSUE_W*NUM_SRC*TAG_W | Source register tags, same entry order |
| iss_dst_valid | input | ISSUE_W | Per-slot destination valid |
| iss_dst_tag | input | ISSUE_W*TAG_W | Per-slot destination register tag |
| wb_valid | input | NUM_WB | Correct replayed result written, clear request |
| wb_tag | input | NUM_WB*TAG_W | Register cleared by each writeback port |
| iss_squash | output | ISSUE_W | Per-slot squash flag, combinational in the issue cycle |

## Verification
The hardest situation to reach from the ports is a two-level chain resolved entirely inside one issue group while the poisoning violation arrives in that very cycle, since it needs the bypass, the intra-group ordering and the later spread all lined up. The stimulus builds it directly, then issues readers of the indirect destination on the following cycle, and adds the reverse case where only the younger slot is tainted. A sweep over all 64 registers walks the violate, read, clear-and-read, read-again sequence on each one, and a long pseudo-random run on a small tag range produces dense collisions between violations, spreads and clears that are compared with an arithmetic model in the bench.

// File: rtl/pt_pkg.sv
package pt_pkg;

    localparam int unsigned PT_NUM_PREGS = 64;
    localparam int unsigned PT_ISSUE_W   = 2;
    localparam int unsigned PT_NUM_SRC   = 2;
    localparam int unsigned PT_NUM_WB    = 2;
    localparam int unsigned PT_TAG_W     = $clog2(PT_NUM_PREGS);

    // Outcome of checking one issuing instruction.
    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_CLEAN  = 2'd1,
        SLOT_SQUASH = 2'd2
    } slot_state_e;

    // Flat index of one source operand inside the issue group.
    function automatic int unsigned src_index(int unsigned slot, int unsigned src,
                                              int unsigned nsrc);
        return slot * nsrc + src;
    endfunction

endpackage

// File: rtl/pt_tag_decode.sv
module pt_tag_decode #(
    parameter int unsigned NUM_PREGS = 64,
    parameter int unsigned TAG_W     = 6
) (
    input  logic                 valid,
    input  logic [TAG_W-1:0]     tag,
    output logic [NUM_PREGS-1:0] onehot
);
    always_comb begin
        onehot = '0;
        if (valid) onehot[tag] = 1'b1;
    end
endmodule

// File: rtl/pt_poison_file.sv
module pt_poison_file #(
    parameter int unsigned NUM_PREGS = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PREGS-1:0] set_vec,
    input  logic [NUM_PREGS-1:0] clr_vec,
    output logic [NUM_PREGS-1:0] poison_q
);
    // Set has priority over clear for the same register.
    always_ff @(posedge clk) begin
        if (rst) poison_q <= '0;
        else     poison_q <= (poison_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/pt_squash_resolve.sv
module pt_squash_resolve
    import pt_pkg::*;
#(
    parameter int unsigned NUM_PREGS = 64,
    parameter int unsigned TAG_W     = 6,
    parameter int unsigned ISSUE_W   = 2,
    parameter int unsigned NUM_SRC   = 2
) (
    input  logic [NUM_PREGS-1:0]             poison_view,
    input  logic [ISSUE_W-1:0]               iss_valid,
    input  logic [ISSUE_W*NUM_SRC-1:0]       src_valid,
    input  logic [ISSUE_W*NUM_SRC*TAG_W-1:0] src_tag,
    input  logic [ISSUE_W-1:0]               dst_valid,
    input  logic [ISSUE_W*TAG_W-1:0]         dst_tag,
    output logic [ISSUE_W-1:0]               squash,
    output logic [NUM_PREGS-1:0]             spread_vec
);
    slot_state_e          state_c [ISSUE_W];
    logic [ISSUE_W-1:0]   hit_c;
    logic [TAG_W-1:0]     tag_c;
    int unsigned          k_c;

    // Slots resolved oldest first so a younger slot can see an older squash.
    always_comb begin
        hit_c = '0;
        tag_c = '0;
        k_c   = 0;
        for (int i = 0; i < ISSUE_W; i++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                k_c   = src_index(i, s, NUM_SRC);
                tag_c = src_tag[k_c*TAG_W +: TAG_W];
                if (src_valid[k_c]) begin
                    if (poison_view[tag_c]) hit_c[i] = 1'b1;
                    for (int j = 0; j < i; j++) begin
                        if (state_c[j] == SLOT_SQUASH && dst_valid[j] &&
                            dst_tag[j*TAG_W +: TAG_W] == tag_c)
                            hit_c[i] = 1'b1;
                    end
                end
            end
            if (!iss_valid[i])  state_c[i] = SLOT_IDLE;
            else if (hit_c[i])  state_c[i] = SLOT_SQUASH;
            else                state_c[i] = SLOT_CLEAN;
        end
    end

    always_comb begin
        spread_vec = '0;
        for (int i = 0; i < ISSUE_W; i++) begin
            squash[i] = (state_c[i] == SLOT_SQUASH);
            if (squash[i] && dst_valid[i])
                spread_vec[dst_tag[i*TAG_W +: TAG_W]] = 1'b1;
        end
    end
endmodule

// File: rtl/pt_squash_tracker.sv
module pt_squash_tracker
    import pt_pkg::*;
#(
    parameter int unsigned NUM_PREGS = PT_NUM_PREGS,
    parameter int unsigned ISSUE_W   = PT_ISSUE_W,
    parameter int unsigned NUM_SRC   = PT_NUM_SRC,
    parameter int unsigned NUM_WB    = PT_NUM_WB,
    localparam int unsigned TAG_W    = $clog2(NUM_PREGS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             viol_valid,
    input  logic [TAG_W-1:0]                 viol_tag,
    input  logic [ISSUE_W-1:0]               iss_valid,
    input  logic [ISSUE_W*NUM_SRC-1:0]       iss_src_valid,
    input  logic [ISSUE_W*NUM_SRC*TAG_W-1:0] iss_src_tag,
    input  logic [ISSUE_W-1:0]               iss_dst_valid,
    input  logic [ISSUE_W*TAG_W-1:0]         iss_dst_tag,
    input  logic [NUM_WB-1:0]                wb_valid,
    input  logic [NUM_WB*TAG_W-1:0]          wb_tag,
    output logic [ISSUE_W-1:0]               iss_squash
);
    logic [NUM_PREGS-1:0] viol_vec;
    logic [NUM_PREGS-1:0] poison_q;
    logic [NUM_PREGS-1:0] poison_view;
    logic [NUM_PREGS-1:0] spread_vec;
    logic [NUM_PREGS-1:0] clr_vec;
    logic [NUM_PREGS-1:0] set_vec;
    logic [NUM_PREGS-1:0] wb_vec [NUM_WB];

    pt_tag_decode #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_viol_dec (
        .valid (viol_valid),
        .tag   (viol_tag),
        .onehot(viol_vec)
    );

    for (genvar w = 0; w < NUM_WB; w++) begin : g_wb
        pt_tag_decode #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_wb_dec (
            .valid (wb_valid[w]),
            .tag   (wb_tag[w*TAG_W +: TAG_W]),
            .onehot(wb_vec[w])
        );
    end

    always_comb begin
        clr_vec = '0;
        for (int w = 0; w < NUM_WB; w++) clr_vec = clr_vec | wb_vec[w];
    end

    // Violation is bypassed to readers of the same cycle.
    assign poison_view = poison_q | viol_vec;
    assign set_vec     = viol_vec | spread_vec;

    pt_squash_resolve #(
        .NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W),
        .ISSUE_W(ISSUE_W),     .NUM_SRC(NUM_SRC)
    ) u_resolve (
        .poison_view(poison_view),
        .iss_valid  (iss_valid),
        .src_valid  (iss_src_valid),
        .src_tag    (iss_src_tag),
        .dst_valid  (iss_dst_valid),
        .dst_tag    (iss_dst_tag),
        .squash     (iss_squash),
        .spread_vec (spread_vec)
    );

    pt_poison_file #(.NUM_PREGS(NUM_PREGS)) u_file (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .poison_q(poison_q)
    );
endmodule

// File: rtl/pt_squash_tracker_chk.sv
module pt_squash_tracker_chk #(
    parameter int unsigned NUM_PREGS = 64,
    parameter int unsigned ISSUE_W   = 2,
    parameter int unsigned NUM_SRC   = 2,
    parameter int unsigned NUM_WB    = 2,
    localparam int unsigned TAG_W    = $clog2(NUM_PREGS)
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             viol_valid,
    input logic [TAG_W-1:0]                 viol_tag,
    input logic [ISSUE_W-1:0]               iss_valid,
    input logic [ISSUE_W*NUM_SRC-1:0]       iss_src_valid,
    input logic [ISSUE_W*NUM_SRC*TAG_W-1:0] iss_src_tag,
    input logic [ISSUE_W-1:0]               iss_dst_valid,
    input logic [ISSUE_W*TAG_W-1:0]         iss_dst_tag,
    input logic [NUM_WB-1:0]                wb_valid,
    input logic [NUM_WB*TAG_W-1:0]          wb_tag,
    input logic [ISSUE_W-1:0]               iss_squash
);
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !viol_valid) |-> (iss_squash == '0));

    p_viol_bypass_r3: assert property (@(posedge clk) disable iff (rst)
        (viol_valid && iss_valid[0] && iss_src_valid[0] &&
         iss_src_tag[TAG_W-1:0] == viol_tag) |-> iss_squash[0]);

    p_spread_next_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(iss_squash[0] && iss_dst_valid[0] && wb_valid == '0) &&
         iss_valid[0] && iss_src_valid[0] &&
         iss_src_tag[TAG_W-1:0] == $past(iss_dst_tag[TAG_W-1:0])) |-> iss_squash[0]);

    p_clear_next_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wb_valid[0]) && !$past(viol_valid) &&
         $past(iss_squash) == '0 && !viol_valid &&
         iss_valid[0] && iss_src_valid[0] && !iss_src_valid[1] &&
         iss_src_tag[TAG_W-1:0] == $past(wb_tag[TAG_W-1:0])) |-> !iss_squash[0]);

    for (genvar i = 0; i < ISSUE_W; i++) begin : g_idle
        p_idle_slot_r7: assert property (@(posedge clk) disable iff (rst)
            !iss_valid[i] |-> !iss_squash[i]);
    end

    if (ISSUE_W > 1) begin : g_chain
        p_group_chain_r6: assert property (@(posedge clk) disable iff (rst)
            (iss_squash[0] && iss_dst_valid[0] && iss_valid[1] &&
             iss_src_valid[NUM_SRC] &&
             iss_src_tag[NUM_SRC*TAG_W +: TAG_W] == iss_dst_tag[TAG_W-1:0])
            |-> iss_squash[1]);
    end
endmodule

bind pt_squash_tracker pt_squash_tracker_chk #(
    .NUM_PREGS(NUM_PREGS), .ISSUE_W(ISSUE_W), .NUM_SRC(NUM_SRC), .NUM_WB(NUM_WB)
) u_chk (.*);

// File: tb/sim_pt_squash_tracker.sv
`timescale 1ns/1ps
module sim_pt_squash_tracker;
    import pt_pkg::*;

    localparam int NP = PT_NUM_PREGS;
    localparam int IW = PT_ISSUE_W;
    localparam int NS = PT_NUM_SRC;
    localparam int NW = PT_NUM_WB;
    localparam int TW = PT_TAG_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              viol_valid;
    logic [TW-1:0]     viol_tag;
    logic [IW-1:0]     iss_valid;
    logic [IW*NS-1:0]  iss_src_valid;
    logic [IW*NS*TW-1:0] iss_src_tag;
    logic [IW-1:0]     iss_dst_valid;
    logic [IW*TW-1:0]  iss_dst_tag;
    logic [NW-1:0]     wb_valid;
    logic [NW*TW-1:0]  wb_tag;
    logic [IW-1:0]     iss_squash;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;
    bit  model [NP];

    always #4 clk = ~clk;

    pt_squash_tracker u0 (.*);

    task automatic idle();
        viol_valid = 0; viol_tag = '0; iss_valid = '0; iss_src_valid = '0;
        iss_src_tag = '0; iss_dst_valid = '0; iss_dst_tag = '0;
        wb_valid = '0; wb_tag = '0;
    endtask

    task automatic rd(input int slot, input int s, input int tag);
        iss_valid[slot] = 1'b1;
        iss_src_valid[slot*NS+s] = 1'b1;
        iss_src_tag[(slot*NS+s)*TW +: TW] = TW'(tag);
    endtask

    task automatic wr(input int slot, input int tag);
        iss_valid[slot] = 1'b1;
        iss_dst_valid[slot] = 1'b1;
        iss_dst_tag[slot*TW +: TW] = TW'(tag);
    endtask

    task automatic violate(input int tag);
        viol_valid = 1'b1; viol_tag = TW'(tag);
    endtask

    task automatic clr(input int port, input int tag);
        wb_valid[port] = 1'b1; wb_tag[port*TW +: TW] = TW'(tag);
    endtask

    task automatic check(input string req, input logic [IW-1:0] got,
                         input logic [IW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: iss_squash=%b expected %b", req, got, exp);
        end
    endtask

    // Drives one cycle with the inputs already set; model follows the requirements.
    task automatic step(input string req, input bit use_exp, input logic [IW-1:0] exp);
        bit              view [NP];
        logic [IW-1:0]   sq;
        int              t;
        bit              hit;
        for (int r = 0; r < NP; r++) view[r] = model[r];
        if (viol_valid) view[viol_tag] = 1;
        sq = '0;
        for (int i = 0; i < IW; i++) begin
            hit = 0;
            for (int s = 0; s < NS; s++) begin
                if (iss_src_valid[i*NS+s]) begin
                    t = int'(iss_src_tag[(i*NS+s)*TW +: TW]);
                    if (view[t]) hit = 1;
                    for (int j = 0; j < i; j++)
                        if (sq[j] && iss_dst_valid[j] &&
                            int'(iss_dst_tag[j*TW +: TW]) == t) hit = 1;
                end
            end
            sq[i] = iss_valid[i] && hit;
        end
        @(negedge clk);
        check(req, iss_squash, use_exp ? exp : sq);
        for (int w = 0; w < NW; w++)
            if (wb_valid[w]) model[int'(wb_tag[w*TW +: TW])] = 0;
        if (viol_valid) model[viol_tag] = 1;
        for (int i = 0; i < IW; i++)
            if (sq[i] && iss_dst_valid[i]) model[int'(iss_dst_tag[i*TW +: TW])] = 1;
        @(posedge clk); #1;
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle();
        for (int r = 0; r < NP; r++) model[r] = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: everything clean after reset
        for (int r = 0; r < NP; r += 2) begin
            rd(0, 0, r); rd(1, 1, r + 1);
            step("R1", 1, 2'b00);
        end

        // Per-register sweep: bypass, persistence, clear timing
        for (int r = 0; r < NP; r++) begin
            violate(r); rd(0, 1, r); rd(1, 0, (r + 1) % NP);
            iss_src_tag[0 +: TW] = TW'(r);          // R4: invalid source 0 holds r
            step("R3", 1, 2'b01);
            iss_src_valid[0] = 1'b1; iss_src_tag[0 +: TW] = TW'(r); // slot 0 not issued
            rd(1, 1, r);
            step("R2", 1, 2'b10);
            clr(0, r); rd(0, 0, r);
            step("R8", 1, 2'b01);
            rd(0, 0, r); rd(1, 0, (r + 5) % NP);
            step("R8", 1, 2'b00);
        end

        // R6 / R5: chains inside a group and across cycles
        violate(10); rd(0, 0, 10); wr(0, 20); rd(1, 1, 20); wr(1, 30);
        step("R6", 1, 2'b11);
        rd(0, 0, 30); rd(1, 0, 20);
        step("R5", 1, 2'b11);
        rd(1, 0, 30); wr(1, 40); rd(0, 0, 40);
        step("R6", 1, 2'b10);
        rd(0, 1, 40);
        step("R5", 1, 2'b01);
        clr(0, 10); clr(1, 20);
        step("R8", 1, 2'b00);
        clr(0, 30); clr(1, 40);
        step("R8", 1, 2'b00);
        rd(0, 0, 10); rd(1, 0, 20);
        step("R8", 1, 2'b00);
        rd(0, 0, 30); rd(1, 1, 40);
        step("R7", 1, 2'b00);

        // R9: set wins over clear
        violate(5); clr(0, 5); rd(0, 0, 6);
        step("R9", 1, 2'b00);
        rd(0, 0, 5); wr(0, 7); clr(1, 7);
        step("R9", 1, 2'b01);
        rd(0, 0, 7); rd(1, 0, 5);
        step("R9", 1, 2'b11);
        clr(0, 5); clr(1, 7);
        step("R8", 1, 2'b00);

        // R4: source valid bits gate the lookup
        violate(9);
        step("R2", 1, 2'b00);
        iss_valid = 2'b11;
        iss_src_tag[0 +: TW] = TW'(9);   rd(0, 1, 8);
        iss_src_tag[2*TW +: TW] = TW'(9); rd(1, 1, 9);
        step("R4", 1, 2'b10);
        clr(0, 9);
        step("R8", 1, 2'b00);

        // Dense pseudo-random traffic on a small tag range
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 7) == 0) violate($urandom_range(0, 7));
            for (int i = 0; i < IW; i++) begin
                if ($urandom_range(0, 3) != 0) begin
                    iss_valid[i] = 1'b1;
                    for (int s = 0; s < NS; s++)
                        if ($urandom_range(0, 1) == 1) rd(i, s, $urandom_range(0, 7));
                    if ($urandom_range(0, 2) != 0) wr(i, $urandom_range(0, 7));
                end
            end
            for (int w = 0; w < NW; w++)
                if ($urandom_range(0, 2) == 0) clr(w, $urandom_range(0, 7));
            step("R5/R7 random", 0, 2'b00);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule